// File: doc/BRIEF.md
# Pixel ADU-to-Photon Converter Column

This block is the per-pixel digital back end of a charge-integrating detector, built as a column of pixels. Each pixel takes a raw 12-bit ADC sample and a 2-bit gain-range code from its analog front end. It adds an offset chosen by the gain range, clamps the sum to the 12-bit range, and divides it by a divisor chosen by the same range. The quotient is a photon count. A digital noise floor then zeroes any count below a programmable threshold. The division is a bit-serial restoring divider that needs a fixed number of cycles, and a per-pixel valid flag shows when the result is ready.

The results leave the column through a pixel-to-pixel shift chain. Each pixel owns one 12-bit chain register. When frame sync is high, every chain register captures its own pixel's result. When it is low, every register takes the word held by the pixel before it, so the column moves one word toward the edge on each clock. The column shares one calibration set, written through a small address/data port: three offsets, three divisors and one threshold.

Top module: `adu_pixel_column`

## Requirements
- R1: The pixel adds the selected signed 13-bit offset to the sample. The sum is clamped to 0 when negative and to 4095 when above 4095, and the clamped value is the dividend.
- R2: Gain codes 0, 1 and 2 select calibration range 0, 1 and 2 for both the offset and the divisor. Gain code 3 uses range 2.
- R3: The photon count is the clamped dividend divided by the selected 12-bit divisor, with the fraction dropped.
- R4: A divisor of zero produces a count of 4095.
- R5: A count strictly below the threshold becomes 0. A count equal to or above the threshold passes unchanged.
- R6: The calibration port writes on a clock edge while the write enable is high. The address map is: 0, 1, 2 for offsets of ranges 0 to 2; 4, 5, 6 for divisors of ranges 0 to 2; 8 for the threshold. Writes to any other address change nothing. Written values persist across frames.
- R7: After the edge that samples conversion start, every valid flag is low on the following cycle. The flags rise together exactly 12 clock edges after that start edge. A flag and its result then hold until the next start.
- R8: On a clock edge with frame sync high, every chain register loads its own pixel's current result.
- R9: On a clock edge with frame sync low, each chain register takes the word from the pixel before it, and pixel 0 takes the chain input. After a load, the chain output shows pixel PIXELS-1 first, then PIXELS-2, and so on down to pixel 0, followed by the chain input words.
- R10: After reset, the chain output is 0 and every valid flag is low. The calibration defaults are offsets 0, divisors 1 and threshold 0, so a conversion returns the sample itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout and conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Calibration write enable |
| cfg_addr | input | 4 | Calibration register address |
| cfg_wdata | input | 13 | Calibration write data (offsets use all 13 bits, divisors and threshold use the low 12) |
| conv_start | input | 1 | Starts a conversion in every pixel from the present samples |
| samples | input | PIXELS*12 | ADC samples, pixel p in bits [p*12 +: 12] |
| gains | input | PIXELS*2 | Gain-range codes, pixel p in bits [p*2 +: 2] |
| frame_sync | input | 1 | 1 loads local results into the chain, 0 shifts the chain |
| chain_in | input | 12 | Word entering the chain at pixel 0 |
| chain_out | output | 12 | Chain register of pixel PIXELS-1 |
| conv_valid | output | PIXELS | Per-pixel result-ready flags |

## Verification
A fault in the offset selection, the clamp or the divider's remainder register shows up as a wrong word on the chain output. It appears PIXELS-1-p shift clocks after the next frame-sync load for pixel p, and at most PIXELS clocks after that load. A step counter that is off by one moves the rise of the valid flags away from the twelfth edge, and this is visible the same cycle. A wrong link in the chain shows as words leaving in the wrong order, or as the chain input appearing too early or too late. The sweep repeats under calibration sets that hit clamping, zero divisors and the threshold edge, so each fault is seen within a few hundred conversions.

// File: rtl/adu_pkg.sv
`timescale 1ns/1ps
package adu_pkg;
  localparam int SAMPLE_W = 12;
  localparam int OFFS_W   = 13;
  localparam int GAIN_W   = 2;
  localparam int ADDR_W   = 4;
  localparam int NRANGE   = 3;

  localparam logic [ADDR_W-1:0] CAL_OFS_BASE = 4'd0;
  localparam logic [ADDR_W-1:0] CAL_DIV_BASE = 4'd4;
  localparam logic [ADDR_W-1:0] CAL_THR_ADDR = 4'd8;

  // gain code 3 folds onto the lowest-sensitivity range
  function automatic logic [GAIN_W-1:0] gain_to_range(input logic [GAIN_W-1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/adu_cal_regs.sv
`timescale 1ns/1ps
module adu_cal_regs
  import adu_pkg::*;
#(
  parameter int W  = SAMPLE_W,
  parameter int OW = OFFS_W,
  parameter int NR = NRANGE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [OW-1:0]        cfg_wdata,
  output logic [NR*OW-1:0]     offs_flat,
  output logic [NR*W-1:0]      div_flat,
  output logic [W-1:0]         thr
);
  logic [OW-1:0] offs_q [NR];
  logic [OW-1:0] offs_n [NR];
  logic [W-1:0]  div_q  [NR];
  logic [W-1:0]  div_n  [NR];
  logic [W-1:0]  thr_q, thr_n;
  logic          cal_en;

  assign cal_en = cfg_we;

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      offs_n[r] = offs_q[r];
      div_n[r]  = div_q[r];
      if (cfg_addr == CAL_OFS_BASE + ADDR_W'(r)) offs_n[r] = cfg_wdata;
      if (cfg_addr == CAL_DIV_BASE + ADDR_W'(r)) div_n[r]  = cfg_wdata[W-1:0];
    end
    thr_n = thr_q;
    if (cfg_addr == CAL_THR_ADDR) thr_n = cfg_wdata[W-1:0];
  end

  genvar r;
  generate
    for (r = 0; r < NR; r++) begin : g_range
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          offs_q[r] <= '0;
          div_q[r]  <= W'(1);
        end else if (cal_en) begin
          offs_q[r] <= offs_n[r];
          div_q[r]  <= div_n[r];
        end
      end
      assign offs_flat[r*OW +: OW] = offs_q[r];
      assign div_flat[r*W +: W]    = div_q[r];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (cal_en) thr_q <= thr_n;
  end

  assign thr = thr_q;
endmodule

// File: rtl/adu_pixel_conv.sv
`timescale 1ns/1ps
module adu_pixel_conv
  import adu_pkg::*;
#(
  parameter int W  = SAMPLE_W,
  parameter int OW = OFFS_W,
  parameter int NR = NRANGE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      sample,
  input  logic [GAIN_W-1:0] gain,
  input  logic [NR*OW-1:0]  offs_flat,
  input  logic [NR*W-1:0]   div_flat,
  input  logic [W-1:0]      thr,
  output logic [W-1:0]      result,
  output logic              valid
);
  localparam int CW = $clog2(W);
  localparam logic [W-1:0] CNT_MAX = W'((1 << W) - 1);
  localparam logic signed [OW+1:0] SUM_MAX = (OW+2)'((1 << W) - 1);

  int                   rng;
  logic [OW-1:0]        offs_sel;
  logic [W-1:0]         div_sel;
  logic signed [OW+1:0] sum_s;
  logic [W-1:0]         dividend;

  // offset stage with clamp
  always_comb begin
    rng      = int'(gain_to_range(gain));
    offs_sel = offs_flat[rng*OW +: OW];
    div_sel  = div_flat[rng*W +: W];
    sum_s    = $signed({{(OW+2-W){1'b0}}, sample}) +
               $signed({{2{offs_sel[OW-1]}}, offs_sel});
    if (sum_s[OW+1])          dividend = '0;
    else if (sum_s > SUM_MAX) dividend = CNT_MAX;
    else                      dividend = sum_s[W-1:0];
  end

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  rem_q, rem_n;
  logic [W-1:0]  dq_q, dq_n;
  logic [W-1:0]  dvs_q, dvs_n;
  logic [W-1:0]  res_q, res_n;
  logic          valid_q, valid_n;
  logic          step_en;

  logic [W:0]    rem_shift;
  logic          ge;
  logic [W-1:0]  quot;
  logic [W-1:0]  count;

  assign step_en = start | busy_q;

  always_comb begin
    rem_shift = {rem_q, dq_q[W-1]};
    ge        = rem_shift >= {1'b0, dvs_q};
    quot      = {dq_q[W-2:0], ge};
    count     = (dvs_q == '0) ? CNT_MAX : quot;
    if (count < thr) count = '0;

    busy_n  = busy_q;
    cnt_n   = cnt_q;
    rem_n   = rem_q;
    dq_n    = dq_q;
    dvs_n   = dvs_q;
    res_n   = res_q;
    valid_n = valid_q;
    if (start) begin
      busy_n  = 1'b1;
      cnt_n   = '0;
      rem_n   = '0;
      dq_n    = dividend;
      dvs_n   = div_sel;
      valid_n = 1'b0;
    end else if (busy_q) begin
      rem_n = ge ? (rem_shift[W-1:0] - dvs_q) : rem_shift[W-1:0];
      dq_n  = quot;
      cnt_n = cnt_q + CW'(1);
      if (cnt_q == CW'(W-1)) begin
        busy_n  = 1'b0;
        res_n   = count;
        valid_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      rem_q   <= '0;
      dq_q    <= '0;
      dvs_q   <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else if (step_en) begin
      busy_q  <= busy_n;
      cnt_q   <= cnt_n;
      rem_q   <= rem_n;
      dq_q    <= dq_n;
      dvs_q   <= dvs_n;
      res_q   <= res_n;
      valid_q <= valid_n;
    end
  end

  assign result = res_q;
  assign valid  = valid_q;
endmodule

// File: rtl/adu_chain_stage.sv
`timescale 1ns/1ps
module adu_chain_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_local,
  input  logic [W-1:0] local_word,
  input  logic [W-1:0] prev_word,
  output logic [W-1:0] out_word
);
  logic [W-1:0] word_q, word_n;

  always_comb word_n = load_local ? local_word : prev_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_n;
  end

  assign out_word = word_q;
endmodule

// File: rtl/adu_pixel_column.sv
`timescale 1ns/1ps
module adu_pixel_column
  import adu_pkg::*;
#(
  parameter int PIXELS = 4,
  parameter int W      = SAMPLE_W,
  parameter int OW     = OFFS_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [OW-1:0]              cfg_wdata,
  input  logic                       conv_start,
  input  logic [PIXELS*W-1:0]        samples,
  input  logic [PIXELS*GAIN_W-1:0]   gains,
  input  logic                       frame_sync,
  input  logic [W-1:0]               chain_in,
  output logic [W-1:0]               chain_out,
  output logic [PIXELS-1:0]          conv_valid
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NRANGE*OW-1:0] offs_flat;
  logic [NRANGE*W-1:0]  div_flat;
  logic [W-1:0]         thr;

  adu_cal_regs #(.W(W), .OW(OW), .NR(NRANGE)) u_cal (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .offs_flat (offs_flat),
    .div_flat  (div_flat),
    .thr       (thr)
  );

  logic [PIXELS:0][W-1:0]   link;
  logic [PIXELS-1:0][W-1:0] local_res;

  assign link[0] = chain_in;

  genvar p;
  generate
    for (p = 0; p < PIXELS; p++) begin : g_pix
      adu_pixel_conv #(.W(W), .OW(OW), .NR(NRANGE)) u_conv (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .start     (conv_start),
        .sample    (samples[p*W +: W]),
        .gain      (gains[p*GAIN_W +: GAIN_W]),
        .offs_flat (offs_flat),
        .div_flat  (div_flat),
        .thr       (thr),
        .result    (local_res[p]),
        .valid     (conv_valid[p])
      );
      adu_chain_stage #(.W(W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .load_local (frame_sync),
        .local_word (local_res[p]),
        .prev_word  (link[p]),
        .out_word   (link[p+1])
      );
    end
  endgenerate

  assign chain_out = link[PIXELS];
endmodule

// File: rtl/adu_column_checker.sv
`timescale 1ns/1ps
module adu_column_checker #(
  parameter int PIXELS = 4,
  parameter int W      = 12,
  parameter int STEPS  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic              conv_start,
  input logic [W-1:0]      chain_in,
  input logic [W-1:0]      chain_out,
  input logic [PIXELS-1:0] conv_valid,
  input logic [W-1:0]      first_stage,
  input logic [W-1:0]      last_prev,
  input logic [W-1:0]      last_local
);
  localparam int SW = $clog2(STEPS + 2) + 1;
  localparam logic [SW-1:0] SINCE_MAX = '1;

  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_q <= SINCE_MAX;
    else if (conv_start)         since_q <= '0;
    else if (since_q != SINCE_MAX) since_q <= since_q + SW'(1);
  end

  // R9
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> first_stage == $past(chain_in));

  // R9
  shift_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> chain_out == $past(last_prev));

  // R8
  load_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> chain_out == $past(last_local));

  // R7
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> conv_valid == '0);

  // R7
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_valid[0]) |-> since_q == SW'(STEPS));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid[0] && !conv_start) |=> conv_valid[0]);
endmodule

bind adu_pixel_column adu_column_checker #(.PIXELS(PIXELS), .W(W), .STEPS(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .frame_sync  (frame_sync),
  .conv_start  (conv_start),
  .chain_in    (chain_in),
  .chain_out   (chain_out),
  .conv_valid  (conv_valid),
  .first_stage (link[1]),
  .last_prev   (link[PIXELS-1]),
  .last_local  (local_res[PIXELS-1])
);

// File: tb/adu_pixel_column_test.sv
`timescale 1ns/1ps
module adu_pixel_column_test;
  localparam int P  = 4;
  localparam int W  = 12;
  localparam int OW = 13;
  localparam int MAXV = (1 << W) - 1;

  logic            clk;
  logic            rst_n;
  logic            cfg_we;
  logic [3:0]      cfg_addr;
  logic [OW-1:0]   cfg_wdata;
  logic            conv_start;
  logic [P*W-1:0]  samples;
  logic [P*2-1:0]  gains;
  logic            frame_sync;
  logic [W-1:0]    chain_in;
  logic [W-1:0]    chain_out;
  logic [P-1:0]    conv_valid;

  adu_pixel_column #(.PIXELS(P), .W(W), .OW(OW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .conv_start(conv_start), .samples(samples),
    .gains(gains), .frame_sync(frame_sync), .chain_in(chain_in),
    .chain_out(chain_out), .conv_valid(conv_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int m_off [3];
  int m_div [3];
  int m_thr;

  function automatic int model(input int s, input int g);
    int r, sum, q;
    r = (g == 3) ? 2 : g;
    sum = s + m_off[r];
    if (sum < 0) sum = 0;
    if (sum > MAXV) sum = MAXV;
    if (m_div[r] == 0) q = MAXV;
    else q = sum / m_div[r];
    if (q < m_thr) q = 0;
    return q;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_addr  = 4'(a);
    cfg_wdata = OW'(d);
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // R6: map 0..2 offsets, 4..6 divisors, 8 threshold; junk elsewhere ignored
  task automatic load_cal(input int o0, input int o1, input int o2,
                          input int d0, input int d1, input int d2, input int t);
    wr(0, o0); wr(1, o1); wr(2, o2);
    wr(4, d0); wr(5, d1); wr(6, d2);
    wr(8, t);
    wr(3, 13'h1555); wr(7, 13'h0abc); wr(9, 13'h0fff); wr(15, 13'h1001);
    m_off[0] = o0; m_off[1] = o1; m_off[2] = o2;
    m_div[0] = d0; m_div[1] = d1; m_div[2] = d2;
    m_thr = t;
  endtask

  task automatic run_batch(input int s [P], input int g [P], input int marker, input string tag);
    int e [P];
    for (int p = 0; p < P; p++) begin
      samples[p*W +: W] = W'(s[p]);
      gains[p*2 +: 2]   = 2'(g[p]);
      e[p] = model(s[p], g[p]);
    end
    chain_in   = W'(marker);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    check("R7 valid low after start", int'(conv_valid), 0);
    repeat (11) @(negedge clk);
    check("R7 valid not before 12th edge", int'(conv_valid), 0);
    @(negedge clk);
    check("R7 valid at 12th edge", int'(conv_valid), (1 << P) - 1);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    check({tag, " R8 load, pixel P-1 first"}, int'(chain_out), e[P-1]);
    for (int k = 1; k < P; k++) begin
      @(negedge clk);
      check({tag, " R9 shift order"}, int'(chain_out), e[P-1-k]);
    end
    @(negedge clk);
    check("R9 chain input follows column", int'(chain_out), marker & MAXV);
  endtask

  int s [P];
  int g [P];

  task automatic sweep(input int nb, input string tag);
    for (int b = 0; b < nb; b++) begin
      for (int p = 0; p < P; p++) begin
        if (b == 0) s[p] = (p % 2 == 0) ? 0 : MAXV;
        else s[p] = (b * 61 + p * 1031 + 7) % 4096;
        g[p] = (b + p * 3) % 4;
      end
      run_batch(s, g, (b * 37 + 5) % 4096, tag);
    end
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    conv_start = 1'b0; samples = '0; gains = '0; frame_sync = 1'b0; chain_in = '0;
    m_off[0] = 0; m_off[1] = 0; m_off[2] = 0;
    m_div[0] = 1; m_div[1] = 1; m_div[2] = 1; m_thr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    check("R10 chain_out after reset", int'(chain_out), 0);
    check("R10 valid after reset", int'(conv_valid), 0);
    // R10: default calibration passes samples through
    sweep(8, "R10 defaults");

    // R1 R2 R3: ordinary offsets and divisors per range
    load_cal(0, -100, 300, 1, 3, 7, 0);
    sweep(256, "R1 R2 R3");

    // R1 clamps at both ends, R4 zero divisor, R6 junk writes ignored
    load_cal(-4096, 4095, 50, 0, 4095, 16, 5);
    sweep(256, "R1 R4 R6");

    // R5 threshold edge: 100 passes, 99 drops; R4 zero divisor on range 2
    load_cal(20, -20, 0, 2, 5, 0, 100);
    s[0] = 180; s[1] = 178; s[2] = 4095; s[3] = 0;
    g[0] = 0;   g[1] = 0;   g[2] = 1;    g[3] = 3;
    run_batch(s, g, 77, "R5 R4 directed");
    check("R5 count equal to threshold kept", model(180, 0), 100);

    // R7 results held: reload without a new start gives the same words
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    check("R7 result held for reload", int'(chain_out), model(0, 3));
    @(negedge clk);
    check("R7 result held for reload", int'(chain_out), model(4095, 1));

    // R6 calibration persists across frames
    sweep(64, "R5 R6 persist");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule